// File: doc/BRIEF.md
# I2C Master Controller with Status Codes

This block is a single-master I2C bus controller that software steers through a small byte-wide register window. Two control registers act as a pair: writing ones to the first raises control bits, and writing ones to the second lowers them. Software raises the enable, start, stop and acknowledge bits there. It loads the byte to transmit into a data register, then lowers the interrupt flag to release the engine. After every bus event the engine raises the interrupt flag, holds SCL low and publishes a fixed numeric status code. Software reads that code to decide the next step.

The engine produces start, repeated start and stop conditions. It shifts address and data bytes most significant bit first and either samples or returns the acknowledge bit. SCL high and low times come from two programmable cycle counts. Both bus lines are open-drain: the block only ever pulls a line low or lets it float high. Clock stretching, arbitration and slave operation are not part of the block.

Top module: `i2c_host_ctrl`

## Requirements
- R1: Offset 0 is the control-set register. Writing a 1 to bit 2 (acknowledge enable), bit 3 (interrupt flag), bit 4 (stop request), bit 5 (start request) or bit 6 (enable) sets that bit, and bits written 0 are left unchanged. Reading offset 0 returns the control bits at those positions. All of them are 0 after reset.
- R2: Offset 1 is the control-clear register. Writing a 1 to bit 2, 3, 5 or 6 clears that control bit, writing 0 changes nothing, and the stop bit cannot be cleared from here.
- R3: With the block enabled and the interrupt flag clear, a start request produces SDA falling while SCL is high, then status 0x08. A start request issued while the bus is held after an event produces a repeated start with status 0x10.
- R4: A stop request issued while the bus is held drives SDA low under SCL low, raises SCL, then releases SDA while SCL is high. The stop bit clears itself once this is done, and the status then reads 0xF8 with the interrupt flag clear.
- R5: The first byte after a start or repeated start is the address byte taken from the data register (offset 3): 7-bit address then a direction bit in the LSB (0 write, 1 read). The resulting status is 0x18 (write, ACK), 0x20 (write, NACK), 0x40 (read, ACK) or 0x48 (read, NACK).
- R6: In write direction, each byte from the data register goes out MSB first, with SDA changed only while SCL is low. The resulting status is 0x28 when the slave returns ACK and 0x30 when it returns NACK.
- R7: In read direction, the received byte is loaded into the data register when the event is reported. The master returns ACK (SDA low) when acknowledge enable is 1 and NACK when it is 0, with status 0x50 or 0x58 respectively.
- R8: SCL high time and low time are 16-bit counts of clock cycles, reset to 4. The high count's low and high bytes are at offsets 4 and 5, and the low count's at offsets 6 and 7.
- R9: While the interrupt flag is set after an event, SCL is held low, the status stays frozen, and the status register (offset 2) carries the code in bits 7:3 with bits 2:0 reading 0.
- R10: When enable is 0, both lines are released within one cycle and the status reads 0xF8.
- R11: If stop and start are both requested while the bus is held, a stop condition is sent, followed by a new start reported as 0x08.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt flag (control bit 3) |
| scl_low | output | 1 | Pull SCL low when 1, release when 0 |
| sda_low | output | 1 | Pull SDA low when 1, release when 0 |
| sda_in | input | 1 | Sampled level of the SDA line |

## Verification
The bench drives the controller through every status code using a bus-level slave model.

- A design that shifted bytes LSB first, or that did not place the direction bit at bit 0, would garble the bytes the slave model records against the scoreboard queue.
- A design that ignored the acknowledge-enable bit would return ACK on a byte that should be refused, and the slave model would see it.
- A design that reused the plain start path for a restart would report 0x08 where 0x10 is due.
- Stop and start requested together check that the stop really precedes the new start, because the bench counts both conditions on the wire.
- Measured SCL high and low phase lengths catch an off-by-one in the phase counter.
- Disabling the block while it holds the bus catches a design that leaves a line pulled low.

// File: rtl/i2c_host_pkg.sv
`timescale 1ns/1ps
package i2c_host_pkg;

  // register offsets
  localparam logic [2:0] OFS_CSET  = 3'd0;
  localparam logic [2:0] OFS_CCLR  = 3'd1;
  localparam logic [2:0] OFS_STAT  = 3'd2;
  localparam logic [2:0] OFS_DATA  = 3'd3;
  localparam logic [2:0] OFS_THI_L = 3'd4;
  localparam logic [2:0] OFS_THI_H = 3'd5;
  localparam logic [2:0] OFS_TLO_L = 3'd6;
  localparam logic [2:0] OFS_TLO_H = 3'd7;

  // control bit positions
  localparam int B_AA  = 2;
  localparam int B_SI  = 3;
  localparam int B_STO = 4;
  localparam int B_STA = 5;
  localparam int B_EN  = 6;

  // status codes (value of bits 7:3)
  localparam logic [4:0] SC_IDLE    = 5'h1F;
  localparam logic [4:0] SC_START   = 5'h01;
  localparam logic [4:0] SC_RSTART  = 5'h02;
  localparam logic [4:0] SC_WA_ACK  = 5'h03;
  localparam logic [4:0] SC_WA_NACK = 5'h04;
  localparam logic [4:0] SC_WD_ACK  = 5'h05;
  localparam logic [4:0] SC_WD_NACK = 5'h06;
  localparam logic [4:0] SC_RA_ACK  = 5'h08;
  localparam logic [4:0] SC_RA_NACK = 5'h09;
  localparam logic [4:0] SC_RD_ACK  = 5'h0A;
  localparam logic [4:0] SC_RD_NACK = 5'h0B;

  typedef struct packed {
    logic en;
    logic sta;
    logic sto;
    logic si;
    logic aa;
  } ctrl_t;

  typedef enum logic [3:0] {
    E_IDLE, E_START, E_WAIT, E_BIT_L, E_BIT_H,
    E_RS_L, E_RS_H, E_STOP_L, E_STOP_H, E_STOP_R
  } eng_state_t;

  typedef enum logic [1:0] {M_ADDR, M_TX, M_RX} xfer_mode_t;

endpackage

// File: rtl/i2c_host_regs.sv
`timescale 1ns/1ps
module i2c_host_regs
  import i2c_host_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CNT_RST = 4,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  input  logic              si_set,
  input  logic              sto_clr,
  input  logic              rx_load,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic [4:0]        stat_code,
  output ctrl_t             ctrl,
  output logic [BYTE_W-1:0] data_q,
  output logic [CNT_W-1:0]  thigh,
  output logic [CNT_W-1:0]  tlow
);

  localparam int HI_W = CNT_W - BYTE_W;
  localparam int EXT_W = 2 * BYTE_W;

  logic wr_set, wr_clr;
  logic [EXT_W-1:0] thi_ext, tlo_ext;

  assign wr_set  = reg_wr && (reg_addr == OFS_CSET);
  assign wr_clr  = reg_wr && (reg_addr == OFS_CCLR);
  assign thi_ext = EXT_W'(thigh);
  assign tlo_ext = EXT_W'(tlow);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else begin
      if (sto_clr) ctrl.sto <= 1'b0;
      if (wr_set) begin
        if (reg_wdata[B_AA])  ctrl.aa  <= 1'b1;
        if (reg_wdata[B_SI])  ctrl.si  <= 1'b1;
        if (reg_wdata[B_STO]) ctrl.sto <= 1'b1;
        if (reg_wdata[B_STA]) ctrl.sta <= 1'b1;
        if (reg_wdata[B_EN])  ctrl.en  <= 1'b1;
      end
      if (wr_clr) begin
        if (reg_wdata[B_AA])  ctrl.aa  <= 1'b0;
        if (reg_wdata[B_SI])  ctrl.si  <= 1'b0;
        if (reg_wdata[B_STA]) ctrl.sta <= 1'b0;
        if (reg_wdata[B_EN])  ctrl.en  <= 1'b0;
      end
      if (si_set) ctrl.si <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      thigh  <= CNT_W'(CNT_RST);
      tlow   <= CNT_W'(CNT_RST);
    end else begin
      if (rx_load) begin
        data_q <= rx_byte;
      end else if (reg_wr && reg_addr == OFS_DATA) begin
        data_q <= reg_wdata;
      end
      if (reg_wr) begin
        case (reg_addr)
          OFS_THI_L: thigh[BYTE_W-1:0] <= reg_wdata;
          OFS_THI_H: thigh[CNT_W-1:BYTE_W] <= reg_wdata[HI_W-1:0];
          OFS_TLO_L: tlow[BYTE_W-1:0] <= reg_wdata;
          OFS_TLO_H: tlow[CNT_W-1:BYTE_W] <= reg_wdata[HI_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      OFS_CSET: begin
        reg_rdata[B_AA]  = ctrl.aa;
        reg_rdata[B_SI]  = ctrl.si;
        reg_rdata[B_STO] = ctrl.sto;
        reg_rdata[B_STA] = ctrl.sta;
        reg_rdata[B_EN]  = ctrl.en;
      end
      OFS_STAT:  reg_rdata = {stat_code, 3'b000};
      OFS_DATA:  reg_rdata = data_q;
      OFS_THI_L: reg_rdata = thi_ext[BYTE_W-1:0];
      OFS_THI_H: reg_rdata = thi_ext[EXT_W-1:BYTE_W];
      OFS_TLO_L: reg_rdata = tlo_ext[BYTE_W-1:0];
      OFS_TLO_H: reg_rdata = tlo_ext[EXT_W-1:BYTE_W];
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/i2c_host_engine.sv
`timescale 1ns/1ps
module i2c_host_engine
  import i2c_host_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  input  logic [BYTE_W-1:0] data_q,
  input  logic [CNT_W-1:0]  thigh,
  input  logic [CNT_W-1:0]  tlow,
  input  logic              sda_in,
  output logic              scl_low,
  output logic              sda_low,
  output logic [4:0]        stat_code,
  output logic              si_set,
  output logic              sto_clr,
  output logic              rx_load,
  output logic [BYTE_W-1:0] rx_byte,
  output logic              eng_hold
);

  localparam int BIT_W = $clog2(BYTE_W + 1);
  localparam logic [BIT_W-1:0] ACK_SLOT = BIT_W'(BYTE_W);
  localparam logic [BIT_W-1:0] LAST_DATA = BIT_W'(BYTE_W - 1);

  eng_state_t        state;
  xfer_mode_t        mode;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitn;
  logic [BYTE_W-1:0] tx_sh;
  logic [BYTE_W-1:0] rx_sh;
  logic              dir_rd;
  logic              aa_l;
  logic              rep;
  logic              pend;
  logic              drv_nxt;
  logic              tm_done;
  logic              ack_seen;
  logic [CNT_W-1:0]  thi_p, tlo_p;

  assign tm_done  = (cnt <= CNT_W'(1));
  assign ack_seen = !sda_in;
  assign thi_p    = (thigh == '0) ? CNT_W'(1) : thigh;
  assign tlo_p    = (tlow == '0) ? CNT_W'(1) : tlow;
  assign eng_hold = (state == E_WAIT);
  assign rx_byte  = rx_sh;

  // event strobes: registered with the engine's own transition into the hold state
  assign si_set  = ctrl.en && tm_done &&
                   ((state == E_START) || (state == E_BIT_H && bitn == ACK_SLOT));
  assign rx_load = ctrl.en && tm_done && state == E_BIT_H &&
                   bitn == ACK_SLOT && mode == M_RX;
  assign sto_clr = ctrl.en && ((state == E_STOP_R && tm_done) ||
                               (state == E_IDLE && ctrl.sto));

  always_ff @(posedge clk) begin
    if (rst || !ctrl.en) begin
      state     <= E_IDLE;
      mode      <= M_ADDR;
      scl_low   <= 1'b0;
      sda_low   <= 1'b0;
      stat_code <= SC_IDLE;
      cnt       <= CNT_W'(1);
      bitn      <= '0;
      tx_sh     <= '0;
      rx_sh     <= '0;
      dir_rd    <= 1'b0;
      aa_l      <= 1'b0;
      rep       <= 1'b0;
      pend      <= 1'b0;
      drv_nxt   <= 1'b0;
    end else begin
      if (cnt > CNT_W'(1)) cnt <= cnt - CNT_W'(1);
      case (state)
        E_IDLE: begin
          scl_low <= 1'b0;
          sda_low <= 1'b0;
          if (!ctrl.sto && ctrl.sta && !ctrl.si) begin
            sda_low <= 1'b1;
            rep     <= 1'b0;
            cnt     <= thi_p;
            state   <= E_START;
          end
        end
        E_START: begin
          if (tm_done) begin
            scl_low   <= 1'b1;
            stat_code <= rep ? SC_RSTART : SC_START;
            mode      <= M_ADDR;
            state     <= E_WAIT;
          end
        end
        E_WAIT: begin
          if (!ctrl.si) begin
            stat_code <= SC_IDLE;
            cnt       <= tlo_p;
            if (ctrl.sto) begin
              sda_low <= 1'b1;
              state   <= E_STOP_L;
            end else if (ctrl.sta) begin
              sda_low <= 1'b0;
              state   <= E_RS_L;
            end else begin
              tx_sh   <= data_q;
              aa_l    <= ctrl.aa;
              bitn    <= '0;
              pend    <= 1'b1;
              drv_nxt <= (mode == M_RX) ? 1'b0 : !data_q[BYTE_W-1];
              if (mode == M_ADDR) dir_rd <= data_q[0];
              state   <= E_BIT_L;
            end
          end
        end
        E_BIT_L: begin
          if (pend) begin
            sda_low <= drv_nxt;
            pend    <= 1'b0;
          end else if (tm_done) begin
            scl_low <= 1'b0;
            cnt     <= thi_p;
            state   <= E_BIT_H;
          end
        end
        E_BIT_H: begin
          if (tm_done) begin
            scl_low <= 1'b1;
            if (bitn == ACK_SLOT) begin
              state <= E_WAIT;
              case (mode)
                M_ADDR: begin
                  mode <= dir_rd ? M_RX : M_TX;
                  if (dir_rd) stat_code <= ack_seen ? SC_RA_ACK : SC_RA_NACK;
                  else        stat_code <= ack_seen ? SC_WA_ACK : SC_WA_NACK;
                end
                M_TX:    stat_code <= ack_seen ? SC_WD_ACK : SC_WD_NACK;
                default: stat_code <= aa_l ? SC_RD_ACK : SC_RD_NACK;
              endcase
            end else begin
              if (mode == M_RX) rx_sh <= {rx_sh[BYTE_W-2:0], sda_in};
              tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
              bitn  <= bitn + BIT_W'(1);
              pend  <= 1'b1;
              if (bitn == LAST_DATA) drv_nxt <= (mode == M_RX) ? aa_l : 1'b0;
              else                   drv_nxt <= (mode == M_RX) ? 1'b0 : !tx_sh[BYTE_W-2];
              cnt   <= tlo_p;
              state <= E_BIT_L;
            end
          end
        end
        E_RS_L: begin
          if (tm_done) begin
            scl_low <= 1'b0;
            cnt     <= thi_p;
            state   <= E_RS_H;
          end
        end
        E_RS_H: begin
          if (tm_done) begin
            sda_low <= 1'b1;
            rep     <= 1'b1;
            cnt     <= thi_p;
            state   <= E_START;
          end
        end
        E_STOP_L: begin
          if (tm_done) begin
            scl_low <= 1'b0;
            cnt     <= thi_p;
            state   <= E_STOP_H;
          end
        end
        E_STOP_H: begin
          if (tm_done) begin
            sda_low <= 1'b0;
            cnt     <= thi_p;
            state   <= E_STOP_R;
          end
        end
        E_STOP_R: begin
          if (tm_done) state <= E_IDLE;
        end
        default: state <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2c_host_ctrl.sv
`timescale 1ns/1ps
module i2c_host_ctrl
  import i2c_host_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CNT_RST = 4,
  parameter int BYTE_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [BYTE_W-1:0] reg_wdata,
  output logic [BYTE_W-1:0] reg_rdata,
  output logic              irq,
  output logic              scl_low,
  output logic              sda_low,
  input  logic              sda_in
);

  ctrl_t             ctrl;
  logic [BYTE_W-1:0] data_q;
  logic [CNT_W-1:0]  thigh, tlow;
  logic [4:0]        stat_code;
  logic              si_set, sto_clr, rx_load, eng_hold;
  logic [BYTE_W-1:0] rx_byte;

  assign irq = ctrl.si;

  i2c_host_regs #(.CNT_W(CNT_W), .CNT_RST(CNT_RST), .BYTE_W(BYTE_W)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .si_set    (si_set),
    .sto_clr   (sto_clr),
    .rx_load   (rx_load),
    .rx_byte   (rx_byte),
    .stat_code (stat_code),
    .ctrl      (ctrl),
    .data_q    (data_q),
    .thigh     (thigh),
    .tlow      (tlow)
  );

  i2c_host_engine #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_eng (
    .clk       (clk),
    .rst       (rst),
    .ctrl      (ctrl),
    .data_q    (data_q),
    .thigh     (thigh),
    .tlow      (tlow),
    .sda_in    (sda_in),
    .scl_low   (scl_low),
    .sda_low   (sda_low),
    .stat_code (stat_code),
    .si_set    (si_set),
    .sto_clr   (sto_clr),
    .rx_load   (rx_load),
    .rx_byte   (rx_byte),
    .eng_hold  (eng_hold)
  );

endmodule

// File: rtl/i2c_host_chk.sv
`timescale 1ns/1ps
module i2c_host_chk
  import i2c_host_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input ctrl_t      ctrl,
  input logic       scl_low,
  input logic       sda_low,
  input logic [4:0] stat_code,
  input logic       eng_hold
);

  // R10
  dis_release_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.en |=> (!scl_low && !sda_low && stat_code == SC_IDLE));

  // R9
  frozen_code_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_hold && $past(eng_hold)) |-> $stable(stat_code));

  // R9
  hold_scl_chk: assert property (@(posedge clk) disable iff (rst)
    eng_hold |-> scl_low);

  // R4
  sto_self_clr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ctrl.sto) |-> (!scl_low && !sda_low));

  // R3
  start_cond_chk: assert property (@(posedge clk) disable iff (rst || !ctrl.en)
    (!scl_low && !$past(scl_low) && $rose(sda_low) && $past(ctrl.en)) |-> ctrl.sta);

  // R4
  stop_cond_chk: assert property (@(posedge clk) disable iff (rst || !ctrl.en)
    (!scl_low && !$past(scl_low) && $fell(sda_low) && $past(ctrl.en)) |-> ctrl.sto);

endmodule

bind i2c_host_ctrl i2c_host_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctrl      (ctrl),
  .scl_low   (scl_low),
  .sda_low   (sda_low),
  .stat_code (stat_code),
  .eng_hold  (eng_hold)
);

// File: tb/i2c_host_ctrl_tb.sv
`timescale 1ns/1ps
module i2c_host_ctrl_tb;

  localparam logic [6:0] SLV = 7'h4F;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_wr = 1'b0;
  logic [2:0] reg_addr = 3'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       irq, scl_low, sda_low;
  logic       slv_drv = 1'b0;
  logic       scl_line, sda_line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  assign scl_line = !scl_low;
  assign sda_line = !(sda_low || slv_drv);

  i2c_host_ctrl u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .scl_low(scl_low), .sda_low(sda_low), .sda_in(sda_line)
  );

  // scoreboard queue of bytes the slave must see on the wire
  logic [7:0] exp_q[$];

  // slave model state
  int         sl_bits = 0;
  bit         sl_first = 0, sl_read = 0, sl_match = 0, sl_tx = 0;
  bit         sl_ack_en = 1, m_ack = 0;
  logic [7:0] sl_sh = 0;
  logic [7:0] sl_rd [2] = '{8'hC3, 8'h5A};
  int         rd_idx = 0, starts = 0, stops = 0;
  int         run = 0, hi_len = 0, lo_len = 0;
  logic       p_scl = 1, p_sda = 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: bus-level slave and scoreboard compare
  always @(posedge clk) begin
    if (rst) begin
      sl_bits = 0; slv_drv = 0; p_scl = 1; p_sda = 1; run = 0;
    end else begin
      if (scl_line != p_scl) begin
        if (p_scl) hi_len = run;
        else if (sl_bits >= 1 && sl_bits <= 8) lo_len = run;
        run = 1;
      end else begin
        run++;
      end
      if (scl_line && p_scl && p_sda && !sda_line) begin
        starts++; sl_bits = 0; sl_first = 1; sl_tx = 0; slv_drv = 0;
      end else if (scl_line && p_scl && !p_sda && sda_line) begin
        stops++; sl_bits = 0; sl_tx = 0;
      end else if (!p_scl && scl_line) begin
        if (sl_bits < 8) begin
          sl_sh = {sl_sh[6:0], sda_line};
          sl_bits++;
          if (sl_bits == 8 && !sl_tx) begin
            checks++;
            if (exp_q.size() == 0) begin
              errors++;
              $display("FAIL R6 actual=%0h expected=none", sl_sh);
            end else begin
              logic [7:0] e;
              e = exp_q.pop_front();
              if (e !== sl_sh) begin
                errors++;
                $display("FAIL R5/R6 wire byte actual=%0h expected=%0h", sl_sh, e);
              end
            end
          end
        end else if (sl_bits == 8) begin
          sl_bits = 9;
          if (sl_tx) begin
            m_ack = !sda_line;
            rd_idx++;
          end
        end
      end else if (p_scl && !scl_line) begin
        if (sl_bits == 8) begin
          if (sl_first) begin
            sl_read = sl_sh[0];
            sl_match = (sl_sh[7:1] == SLV);
            slv_drv = sl_match;
          end else if (!sl_tx) begin
            slv_drv = sl_ack_en;
          end else begin
            slv_drv = 0;
          end
        end else if (sl_bits == 9) begin
          sl_bits = 0;
          slv_drv = 0;
          if (sl_read && sl_match && (sl_first || (sl_tx && m_ack)) && rd_idx < 2) begin
            sl_tx = 1;
            slv_drv = !sl_rd[rd_idx][7];
          end else begin
            sl_tx = 0;
          end
          sl_first = 0;
        end else if (sl_bits >= 1 && sl_bits <= 7 && sl_tx) begin
          slv_drv = !sl_rd[rd_idx][7 - sl_bits];
        end
      end
      p_scl = scl_line;
      p_sda = sda_line;
    end
  end

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic wait_irq(input string req);
    int n = 0;
    while (!irq && n < 20000) begin
      @(negedge clk);
      n++;
    end
    if (!irq) begin
      checks++; errors++;
      $display("FAIL %s actual=timeout expected=irq", req);
    end
  endtask

  // driver: release the engine and expect a status code back
  task automatic go(input logic [7:0] clr, input logic [7:0] exp_stat, input string req);
    logic [7:0] s;
    wr(3'd1, clr);
    wait_irq(req);
    rd(3'd2, s);
    check(req, s, exp_stat);
  endtask

  initial begin
    logic [7:0] v;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);

    // reset state
    rd(3'd0, v); check("R1 reset ctrl", v, 8'h00);
    rd(3'd2, v); check("R9 reset status", v, 8'hF8);
    check("R10 reset lines", {irq, scl_low, sda_low}, 3'b000);
    rd(3'd4, v); check("R8 thigh reset lo", v, 8'h04);
    rd(3'd5, v); check("R8 thigh reset hi", v, 8'h00);
    rd(3'd6, v); check("R8 tlow reset lo", v, 8'h04);

    // set / clear semantics
    wr(3'd0, 8'h44); rd(3'd0, v); check("R1 set", v, 8'h44);
    wr(3'd1, 8'h00); rd(3'd0, v); check("R2 clear zero", v, 8'h44);
    wr(3'd1, 8'h04); rd(3'd0, v); check("R2 clear aa", v, 8'h40);

    // start
    wr(3'd3, {SLV, 1'b0});
    wr(3'd0, 8'h20);
    wait_irq("R3");
    rd(3'd2, v); check("R3 start code", v, 8'h08);
    check("R3 start on wire", starts, 1);
    repeat (20) @(negedge clk);
    check("R9 scl held", scl_low, 1'b1);
    rd(3'd2, v); check("R9 code frozen", v, 8'h08);

    // write address, then data
    exp_q.push_back({SLV, 1'b0});
    go(8'h28, 8'h18, "R5 write addr ack");
    wr(3'd3, 8'hA5); exp_q.push_back(8'hA5);
    go(8'h08, 8'h28, "R6 data ack");

    // new timing, NACKed data byte
    wr(3'd4, 8'd6); wr(3'd5, 8'd0); wr(3'd6, 8'd10); wr(3'd7, 8'd0);
    sl_ack_en = 0;
    wr(3'd3, 8'h3C); exp_q.push_back(8'h3C);
    go(8'h08, 8'h30, "R6 data nack");
    check("R8 scl high len", hi_len, 6);
    check("R8 scl low len", lo_len, 10);
    sl_ack_en = 1;

    // repeated start and read
    wr(3'd0, 8'h20);
    go(8'h08, 8'h10, "R3 repeated start");
    check("R3 restart on wire", starts, 2);
    wr(3'd3, {SLV, 1'b1}); exp_q.push_back({SLV, 1'b1});
    go(8'h28, 8'h40, "R5 read addr ack");
    wr(3'd0, 8'h04);
    go(8'h08, 8'h50, "R7 read ack");
    rd(3'd3, v); check("R7 rx byte 0", v, 8'hC3);
    check("R7 master ack", m_ack, 1'b1);
    go(8'h0C, 8'h58, "R7 read nack");
    rd(3'd3, v); check("R7 rx byte 1", v, 8'h5A);
    check("R7 master nack", m_ack, 1'b0);

    // stop
    wr(3'd0, 8'h10);
    wr(3'd1, 8'h08);
    v = 8'h10;
    for (int i = 0; i < 5000 && v[4]; i++) rd(3'd0, v);
    check("R4 sto self clear", v[4], 1'b0);
    rd(3'd2, v); check("R4 status after stop", v, 8'hF8);
    check("R4 lines released", {irq, scl_low, sda_low}, 3'b000);
    check("R4 stop on wire", stops, 1);

    // address NACK, then stop+start together
    wr(3'd3, 8'h44);
    wr(3'd0, 8'h20);
    wait_irq("R3");
    rd(3'd2, v); check("R3 start again", v, 8'h08);
    exp_q.push_back(8'h44);
    go(8'h28, 8'h20, "R5 write addr nack");
    wr(3'd0, 8'h30);
    go(8'h08, 8'h08, "R11 stop then start");
    check("R11 stop count", stops, 2);
    check("R11 start count", starts, 4);

    // disable while holding the bus
    wr(3'd1, 8'h40);
    repeat (2) @(negedge clk);
    check("R10 lines off", {scl_low, sda_low}, 2'b00);
    rd(3'd2, v); check("R10 status idle", v, 8'hF8);
    check("R6 scoreboard drained", exp_q.size(), 0);

    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule